// File: doc/BRIEF.md
# Trace Capture Window Buffer

This block records a bus of probed internal signals into an on-chip circular sample memory, clocked by its own sampling clock, so that a debug host can later inspect a window of activity around an event. After an arm request the block stores one sample on every rising edge of the sampling clock, overwriting the oldest entry once the memory is full, so the memory always holds the latest history. A single-cycle trigger pulse, produced by external trigger logic, marks the event of interest.

On the trigger the block keeps recording until enough samples follow the event to place it at the chosen position in the window. Three placements are offered: a small share of history before the trigger, an even split, or a large share of history. When the last sample is stored, writing halts and a done flag rises. The host then reads the frozen window through a simple synchronous read port, addressing it as an offset from the oldest sample. If the trigger came too soon after arming for the memory to fill, a count of leading unwritten slots shows where real data starts.

Top module: `trace_capture`

## Requirements
- R1: After reset, `capturing` and `done` are both 0 and no sample is stored until an arm request.
- R2: A clock edge with `armReq` high clears `done`, restarts the write pointer and fill count, latches `posSel`, and makes `capturing` 1 from the next cycle; no sample is stored on that edge.
- R3: While `capturing` is 1 and `armReq` is 0, every rising edge of `sampleClk` stores `probeData`; once DEPTH samples exist, each new one replaces the oldest, so the window holds the most recent DEPTH samples.
- R4: The latched `posSel` sets the pre-trigger count P: code 0 gives floor(DEPTH*12/100), code 2 gives floor(DEPTH*88/100), codes 1 and 3 give DEPTH/2. The post-trigger count is DEPTH-P, and the sample taken on the trigger edge is the first post-trigger sample.
- R5: `done` rises on the edge that stores the last post-trigger sample, at which `capturing` falls; no further sample is stored and `done` stays 1 until the next arm request.
- R6: `triggerIn` is ignored while idle, after the trigger has been accepted, and while `done` is 1; in those states it neither starts nor extends a capture nor alters stored data.
- R7: `rdData` presents, one clock after `rdAddr` is applied, the sample at offset `rdAddr` from the oldest sample of the window (offset 0 is the oldest, offset DEPTH-1 the newest).
- R8: With `done` at 1, `validStart` equals DEPTH minus the number of samples stored since arming when that number is below DEPTH, and 0 otherwise; offsets below `validStart` hold no sample of this capture.
- R9: An arm request during a capture in progress abandons it and starts a fresh one, whose window contains only samples stored after the new arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sampleClk | input | 1 | Sampling clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| armReq | input | 1 | Arm request; starts a new capture |
| posSel | input | 2 | Trigger position code, latched on arm |
| triggerIn | input | 1 | Trigger pulse from external trigger logic |
| probeData | input | WIDTH | Probed signal bus, sampled every edge while capturing |
| rdAddr | input | $clog2(DEPTH) | Read offset from the oldest sample |
| rdData | output | WIDTH | Registered sample at the read offset |
| capturing | output | 1 | Capture in progress (before or after trigger) |
| done | output | 1 | Capture window complete and frozen |
| validStart | output | $clog2(DEPTH)+1 | Number of leading unwritten slots in the window |

## Verification
The properties assume that the arm request is the only way out of the done state and that the trigger matters only between arming and acceptance; they take the sampling clock as free-running and the reset as synchronous. The stimulus drives every input on the falling edge, holds the arm request for exactly one cycle, and raises the trigger for one cycle at a chosen sample index, sweeping that index from the first sample past the point where the memory wraps for every position code. Stray trigger pulses are placed only in idle or done phases, and readback happens only after done, so the expected window follows from the sample index arithmetic alone.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2,
    CAP_DONE = 2'd3
  } capState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // restart pointers and fill count
    logic write;   // store one sample this edge
  } capStrobe_t;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       armReq,
  input  logic       triggerIn,
  input  logic [1:0] posSel,
  output capStrobe_t strobe,
  output logic       capturing,
  output logic       done
);

  localparam int PRE_NARROW = (DEPTH * 12) / 100;
  localparam int PRE_HALF   = DEPTH / 2;
  localparam int PRE_WIDE   = (DEPTH * 88) / 100;

  function automatic logic [CW-1:0] postFor(input logic [1:0] sel);
    case (sel)
      2'd0:    return CW'(DEPTH - PRE_NARROW);
      2'd2:    return CW'(DEPTH - PRE_WIDE);
      default: return CW'(DEPTH - PRE_HALF);
    endcase
  endfunction

  capState_t       state;
  logic [CW-1:0]   postTarget;
  logic [CW-1:0]   postCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= CAP_IDLE;
      postTarget <= '0;
      postCnt    <= '0;
    end else if (armReq) begin
      state      <= CAP_PRE;
      postTarget <= postFor(posSel);
      postCnt    <= '0;
    end else begin
      case (state)
        CAP_PRE: begin
          if (triggerIn) begin
            postCnt <= CW'(1);
            state   <= (postTarget == CW'(1)) ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          postCnt <= postCnt + CW'(1);
          if (postCnt + CW'(1) == postTarget) state <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clear = armReq;
    strobe.write = !armReq && (state == CAP_PRE || state == CAP_POST);
  end

  assign capturing = (state == CAP_PRE) || (state == CAP_POST);
  assign done      = (state == CAP_DONE);

endmodule

// File: rtl/trace_dpath.sv
module trace_dpath
  import trace_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  input  logic [WIDTH-1:0] probeData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData,
  output logic [AW:0]      validStart
);

  logic [WIDTH-1:0] sampleMem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW:0]      fillCnt;

  always_ff @(posedge clk) begin
    if (strobe.write) sampleMem[wrPtr] <= probeData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (strobe.clear) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (strobe.write) begin
      wrPtr <= wrPtr + AW'(1);
      if (fillCnt != (AW+1)'(DEPTH)) fillCnt <= fillCnt + (AW+1)'(1);
    end
  end

  // Oldest sample sits at the next write slot; offsets wrap modulo DEPTH
  always_ff @(posedge clk) begin
    rdData <= sampleMem[wrPtr + rdAddr];
  end

  assign validStart = (AW+1)'(DEPTH) - fillCnt;

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             sampleClk,
  input  logic             rstN,
  input  logic             armReq,
  input  logic [1:0]       posSel,
  input  logic             triggerIn,
  input  logic [WIDTH-1:0] probeData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData,
  output logic             capturing,
  output logic             done,
  output logic [AW:0]      validStart
);

  capStrobe_t strobe;

  trace_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk       (sampleClk),
    .rstN      (rstN),
    .armReq    (armReq),
    .triggerIn (triggerIn),
    .posSel    (posSel),
    .strobe    (strobe),
    .capturing (capturing),
    .done      (done)
  );

  trace_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_dpath (
    .clk        (sampleClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .probeData  (probeData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .validStart (validStart)
  );

endmodule

// File: rtl/trace_capture_checker.sv
module trace_capture_checker #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          sampleClk,
  input logic          rstN,
  input logic          armReq,
  input logic          capturing,
  input logic          done,
  input logic [AW:0]   validStart
);

  assert_arm_starts_R2: assert property (@(posedge sampleClk) disable iff (!rstN)
    armReq |=> (capturing && !done));

  assert_done_exclusive_R5: assert property (@(posedge sampleClk) disable iff (!rstN)
    !(done && capturing));

  assert_done_from_capture_R5: assert property (@(posedge sampleClk) disable iff (!rstN)
    $rose(done) |-> $past(capturing));

  assert_done_holds_R5: assert property (@(posedge sampleClk) disable iff (!rstN)
    (done && !armReq) |=> done);

  assert_no_spurious_start_R6: assert property (@(posedge sampleClk) disable iff (!rstN)
    (!capturing && !armReq) |=> !capturing);

  assert_valid_start_range_R8: assert property (@(posedge sampleClk) disable iff (!rstN)
    done |-> (validStart < (AW+1)'(DEPTH)));

endmodule

bind trace_capture trace_capture_checker #(.DEPTH(DEPTH)) i_checker (
  .sampleClk  (sampleClk),
  .rstN       (rstN),
  .armReq     (armReq),
  .capturing  (capturing),
  .done       (done),
  .validStart (validStart)
);

// File: tb/test_trace_capture.sv
`timescale 1ns/1ps
module test_trace_capture;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic             sampleClk = 1'b0;
  logic             rstN      = 1'b0;
  logic             armReq    = 1'b0;
  logic [1:0]       posSel    = 2'd0;
  logic             triggerIn = 1'b0;
  logic [WIDTH-1:0] probeData = '0;
  logic [AW-1:0]    rdAddr    = '0;
  logic [WIDTH-1:0] rdData;
  logic             capturing;
  logic             done;
  logic [AW:0]      validStart;

  int checkCount = 0;
  int failCount  = 0;

  trace_capture #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_trace_capture (
    .sampleClk (sampleClk),
    .rstN      (rstN),
    .armReq    (armReq),
    .posSel    (posSel),
    .triggerIn (triggerIn),
    .probeData (probeData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .capturing (capturing),
    .done      (done),
    .validStart(validStart)
  );

  always #2.5 sampleClk = ~sampleClk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int postOf(input int sel);
    int pre;
    case (sel)
      0:       pre = (DEPTH * 12) / 100;
      2:       pre = (DEPTH * 88) / 100;
      default: pre = DEPTH / 2;
    endcase
    return DEPTH - pre;
  endfunction

  task automatic armOnce(input int sel);
    @(negedge sampleClk);
    armReq = 1'b1; posSel = 2'(sel); triggerIn = 1'b0;
    @(negedge sampleClk);
    armReq = 1'b0;
    check(capturing == 1'b1, "R2 capturing after arm", int'(capturing), 1);
    check(done == 1'b0, "R2 done cleared by arm", int'(done), 0);
  endtask

  // Arms, writes sample k = base+k, pulses trigger at index trig, then reads back
  task automatic runCapture(input int sel, input int trig, input int base, input string tag);
    int total = trig + postOf(sel);
    int expValid = (DEPTH > total) ? DEPTH - total : 0;
    armOnce(sel);
    posSel = 2'(3 - sel);  // changes after arm must not matter (R4 latch)
    for (int k = 0; k < total; k++) begin
      probeData = WIDTH'(base + k);
      triggerIn = (k == trig);
      @(negedge sampleClk);
      if (k == total - 1) begin
        check(done == 1'b1, "R5 done on last post sample", int'(done), 1);
        check(capturing == 1'b0, "R5 capture ends", int'(capturing), 0);
      end else begin
        check(done == 1'b0, "R4 done not early", int'(done), 0);
      end
    end
    // Stray triggers and new probe values after done (R6)
    for (int j = 0; j < 3; j++) begin
      probeData = WIDTH'(base + 200 + j);
      triggerIn = 1'b1;
      @(negedge sampleClk);
      check(done == 1'b1 && capturing == 1'b0, "R6 trigger ignored when done",
            int'({capturing, done}), 1);
    end
    triggerIn = 1'b0;
    check(int'(validStart) == expValid, "R8 validStart", int'(validStart), expValid);
    for (int o = 0; o < DEPTH; o++) begin
      int idx = total - DEPTH + o;
      rdAddr = AW'(o);
      @(negedge sampleClk);
      if (idx >= 0) begin
        int exp = (base + idx) & ((1 << WIDTH) - 1);
        check(int'(rdData) == exp, {"R7 R3 readout ", tag}, int'(rdData), exp);
      end
    end
  endtask

  initial begin
    #(100000 * 5.0);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sampleClk);
    rstN = 1'b1;
    check(capturing == 1'b0, "R1 reset capturing", int'(capturing), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);

    // Trigger while idle must not start anything (R6, R1)
    for (int j = 0; j < 4; j++) begin
      triggerIn = 1'b1;
      probeData = WIDTH'(j);
      @(negedge sampleClk);
      check(capturing == 1'b0 && done == 1'b0, "R6 trigger ignored when idle",
            int'({capturing, done}), 0);
    end
    triggerIn = 1'b0;

    // Sweep position codes and trigger indices across and past the wrap point
    for (int sel = 0; sel < 4; sel++) begin
      for (int trig = 0; trig <= 20; trig++) begin
        runCapture(sel, trig, sel * 61 + trig * 7, "sweep R4");
      end
    end

    // Re-arm in the middle of a capture (R9), after the trigger was taken
    armOnce(0);
    for (int k = 0; k < 5; k++) begin
      probeData = WIDTH'(150 + k);
      triggerIn = (k == 1);
      @(negedge sampleClk);
    end
    triggerIn = 1'b0;
    check(capturing == 1'b1, "R9 still capturing before re-arm", int'(capturing), 1);
    runCapture(1, 3, 90, "R9 restart");

    // Re-arm before trigger, then a long pre-trigger run wrapping twice (R3, R9)
    armOnce(2);
    for (int k = 0; k < 6; k++) begin
      probeData = WIDTH'(33 + k);
      @(negedge sampleClk);
    end
    runCapture(2, 40, 10, "R3 long wrap");

    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule